// File: doc/BRIEF.md
# Serial Port Bit Clock Generator

This block produces the transmit and receive bit clocks of a synchronous serial port. All of its logic runs on the master clock, and the bit clocks are level signals in that domain. A programmable divider produces a square wave from the master clock. Each direction then takes its clock from one of three places: the divider, the clock of the other direction, or its own clock pin, which is first sampled through a synchronizer.

Each direction has an inversion control. Inversion changes only the clock that the serializer uses inside the chip. It never changes the value driven onto the pin. Each pin has a tri-state driver. The driver can be off, on at all times, or on only while that direction's controller reports an active transfer. The pin can be chosen as the clock source while continuous drive is also chosen. That combination would loop the pin back on itself, so the block reports an error and keeps the driver off.

All configuration inputs are registered once inside the block. Reset clears the divider and every mode field, so both pins start out tri-stated.

Top module: `serclk_unit`

## Requirements
- R1: With a nonzero divide field N (12 bits), the divider output is a 50% square wave that toggles every N master clock cycles, giving a period of 2N. The fastest setting is N=1, with a period of 2. The slowest is N=4095, with a period of 8190.
- R2: With N=0 the divider holds its output low.
- R3: The transmit source field selects 00 = divider, 01 = receive-side clock, 10 = transmit pin, and 11 = divider.
- R4: The receive source field selects 00 = divider, 01 = transmit-side clock, 10 = receive pin, and 11 = divider.
- R5: A direction that selects the opposite clock receives that direction's own source (its divider or its pin), never a cross-fed value. When both directions select the opposite clock, both receive the divider.
- R6: Each clock pin input is sampled through SYNC_STAGES master clock flops (2 by default) before any use.
- R7: The internal clock output equals the selected clock XOR the inversion bit. The pin output value is always the uninverted selected clock.
- R8: The output mode field selects 00 = pin driver off, 01 = driver always on, 10 = driver on only while that direction's active flag is high, and 11 = driver off.
- R9: Source 10 (own pin) together with mode 01 (continuous) raises that direction's error output and keeps its pin driver off.
- R10: Configuration inputs take effect one master clock cycle after they are presented. Reset clears all configuration and divider state, so every output is low and both drivers are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_n_i | input | DIV_W | Divider half-period N in master clock cycles |
| tx_src_i | input | 2 | Transmit clock source select |
| tx_omode_i | input | 2 | Transmit pin output mode |
| tx_inv_i | input | 1 | Invert the internal transmit clock |
| rx_src_i | input | 2 | Receive clock source select |
| rx_omode_i | input | 2 | Receive pin output mode |
| rx_inv_i | input | 1 | Invert the internal receive clock |
| tx_active_i | input | 1 | Transmit transfer in progress |
| rx_active_i | input | 1 | Receive transfer in progress |
| tk_pad_i | input | 1 | Transmit clock pin input |
| rk_pad_i | input | 1 | Receive clock pin input |
| tx_clk_o | output | 1 | Internal transmit clock |
| rx_clk_o | output | 1 | Internal receive clock |
| tk_pad_o | output | 1 | Transmit clock pin output value |
| tk_pad_oe_o | output | 1 | Transmit clock pin driver enable |
| rk_pad_o | output | 1 | Receive clock pin output value |
| rk_pad_oe_o | output | 1 | Receive clock pin driver enable |
| tx_cfg_err_o | output | 1 | Transmit illegal source/mode combination |
| rx_cfg_err_o | output | 1 | Receive illegal source/mode combination |

## Verification
The assertions check the following on every cycle:
- The divider stays low at N=0 and holds its level between terminal counts.
- A driver is never on in the off modes, or outside a transfer in transfer-only mode.
- An error always coincides with a disabled driver.
- The pin value is the internal clock with the inversion removed.

Some behaviour only the bench scenarios can show. These are the exact divider periods at N=1, 3 and 4095, the cross-feed rule including the case where both directions select the opposite clock, the synchronizer latency on the pins, and the one-cycle delay of configuration. The bench shows them by comparing every output, on every cycle, against a behavioural model.

// File: rtl/serclk_pkg.sv
package serclk_pkg;
  localparam int N_DIR = 2;
  localparam int TX    = 0;
  localparam int RX    = 1;

  typedef enum logic [1:0] {
    SRC_DIV = 2'b00,
    SRC_OPP = 2'b01,
    SRC_PIN = 2'b10,
    SRC_RSV = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    OUT_OFF  = 2'b00,
    OUT_CONT = 2'b01,
    OUT_XFER = 2'b10,
    OUT_RSV  = 2'b11
  } omode_e;

  typedef struct packed {
    src_e   src;
    omode_e omode;
    logic   inv;
  } dir_cfg_t;
endpackage

// File: rtl/serclk_div.sv
module serclk_div #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] n_i,
  output logic         div_o
);
  logic [W-1:0] cnt_q;
  logic         div_q;
  logic         term;

  // >= covers N shrinking below the running count
  assign term = (cnt_q >= (n_i - W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (n_i == '0) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      div_q <= ~div_q;
    end else begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign div_o = div_q;

  // R2
  div_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_i == '0) |=> !div_o);

  // R1
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((n_i != '0) && (cnt_q < (n_i - W'(1)))) |=> $stable(div_o));
endmodule

// File: rtl/serclk_sync.sv
module serclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_flops
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end
    assign q_o = sh_q[STAGES-1];
  end
endmodule

// File: rtl/serclk_dir.sv
module serclk_dir
  import serclk_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  dir_cfg_t cfg_i,
  input  logic     own_base_i,
  input  logic     opp_base_i,
  input  logic     active_i,
  output logic     clk_o,
  output logic     pad_o,
  output logic     pad_oe_o,
  output logic     err_o
);
  logic sel;

  assign sel   = (cfg_i.src == SRC_OPP) ? opp_base_i : own_base_i;
  assign err_o = (cfg_i.src == SRC_PIN) && (cfg_i.omode == OUT_CONT);
  assign clk_o = sel ^ cfg_i.inv;
  assign pad_o = sel;

  always_comb begin
    case (cfg_i.omode)
      OUT_CONT: pad_oe_o = ~err_o;
      OUT_XFER: pad_oe_o = active_i;
      default:  pad_oe_o = 1'b0;
    endcase
  end

  // R8
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg_i.omode == OUT_OFF) || (cfg_i.omode == OUT_RSV)) |-> !pad_oe_o);

  // R8
  xfer_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg_i.omode == OUT_XFER) && !active_i) |-> !pad_oe_o);

  // R9
  err_tristate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !pad_oe_o);
endmodule

// File: rtl/serclk_unit.sv
module serclk_unit
  import serclk_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_n_i,
  input  logic [1:0]       tx_src_i,
  input  logic [1:0]       tx_omode_i,
  input  logic             tx_inv_i,
  input  logic [1:0]       rx_src_i,
  input  logic [1:0]       rx_omode_i,
  input  logic             rx_inv_i,
  input  logic             tx_active_i,
  input  logic             rx_active_i,
  input  logic             tk_pad_i,
  input  logic             rk_pad_i,
  output logic             tx_clk_o,
  output logic             rx_clk_o,
  output logic             tk_pad_o,
  output logic             tk_pad_oe_o,
  output logic             rk_pad_o,
  output logic             rk_pad_oe_o,
  output logic             tx_cfg_err_o,
  output logic             rx_cfg_err_o
);
  dir_cfg_t         cfg_d [N_DIR];
  dir_cfg_t         cfg_q [N_DIR];
  logic [DIV_W-1:0] n_q;
  logic             div_clk;
  logic [N_DIR-1:0] pad_in, pad_sync, base, act;
  logic [N_DIR-1:0] clk_v, pad_v, oe_v, err_v;

  always_comb begin
    cfg_d[TX] = '{src: src_e'(tx_src_i), omode: omode_e'(tx_omode_i), inv: tx_inv_i};
    cfg_d[RX] = '{src: src_e'(rx_src_i), omode: omode_e'(rx_omode_i), inv: rx_inv_i};
  end

  assign pad_in = {rk_pad_i, tk_pad_i};
  assign act    = {rx_active_i, tx_active_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q <= '0;
      for (int i = 0; i < N_DIR; i++) cfg_q[i] <= '0;
    end else begin
      n_q <= div_n_i;
      for (int i = 0; i < N_DIR; i++) cfg_q[i] <= cfg_d[i];
    end
  end

  serclk_div #(.W(DIV_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .n_i    (n_q),
    .div_o  (div_clk)
  );

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    serclk_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pad_in[d]),
      .q_o    (pad_sync[d])
    );

    // base excludes the cross path, so two opposite selects cannot loop
    assign base[d] = (cfg_q[d].src == SRC_PIN) ? pad_sync[d] : div_clk;

    serclk_dir i_dir (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_i      (cfg_q[d]),
      .own_base_i (base[d]),
      .opp_base_i (base[N_DIR-1-d]),
      .active_i   (act[d]),
      .clk_o      (clk_v[d]),
      .pad_o      (pad_v[d]),
      .pad_oe_o   (oe_v[d]),
      .err_o      (err_v[d])
    );
  end

  assign tx_clk_o     = clk_v[TX];
  assign rx_clk_o     = clk_v[RX];
  assign tk_pad_o     = pad_v[TX];
  assign rk_pad_o     = pad_v[RX];
  assign tk_pad_oe_o  = oe_v[TX];
  assign rk_pad_oe_o  = oe_v[RX];
  assign tx_cfg_err_o = err_v[TX];
  assign rx_cfg_err_o = err_v[RX];

  // R7
  tx_pad_uninv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tk_pad_o == (tx_clk_o ^ cfg_q[TX].inv));

  // R7
  rx_pad_uninv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rk_pad_o == (rx_clk_o ^ cfg_q[RX].inv));

  // R5
  both_opp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg_q[TX].src == SRC_OPP) && (cfg_q[RX].src == SRC_OPP)) |-> (tk_pad_o == rk_pad_o));
endmodule

// File: tb/test_serclk_unit.sv
`timescale 1ns/1ps
module test_serclk_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] div_n = '0;
  logic [1:0]  tx_src = '0, tx_omode = '0, rx_src = '0, rx_omode = '0;
  logic        tx_inv = 1'b0, rx_inv = 1'b0;
  logic        tx_act = 1'b0, rx_act = 1'b0;
  logic        tk_in = 1'b0, rk_in = 1'b0;
  logic        tx_clk, rx_clk, tk_out, tk_oe, rk_out, rk_oe, tx_err, rx_err;

  int    checks = 0;
  int    failures = 0;
  bit    cmp_en = 1'b0;
  bit    pad_rand = 1'b0;
  bit    done = 1'b0;
  string tag = "R10";

  // behavioural model state
  int   m_n = 0, m_cnt = 0;
  bit   m_div = 0;
  int   m_src[2], m_mode[2];
  bit   m_inv[2];
  bit   m_sq_tk[$], m_sq_rk[$];

  always #4 clk = ~clk;

  serclk_unit i_serclk_unit (
    .clk_i(clk), .rst_ni(rst_n), .div_n_i(div_n),
    .tx_src_i(tx_src), .tx_omode_i(tx_omode), .tx_inv_i(tx_inv),
    .rx_src_i(rx_src), .rx_omode_i(rx_omode), .rx_inv_i(rx_inv),
    .tx_active_i(tx_act), .rx_active_i(rx_act),
    .tk_pad_i(tk_in), .rk_pad_i(rk_in),
    .tx_clk_o(tx_clk), .rx_clk_o(rx_clk),
    .tk_pad_o(tk_out), .tk_pad_oe_o(tk_oe),
    .rk_pad_o(rk_out), .rk_pad_oe_o(rk_oe),
    .tx_cfg_err_o(tx_err), .rx_cfg_err_o(rx_err)
  );

  task automatic model_reset();
    m_n = 0; m_cnt = 0; m_div = 0;
    for (int i = 0; i < 2; i++) begin m_src[i] = 0; m_mode[i] = 0; m_inv[i] = 0; end
    m_sq_tk = '{0, 0};
    m_sq_rk = '{0, 0};
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      if (m_n == 0) begin m_cnt = 0; m_div = 0; end
      else if (m_cnt >= m_n - 1) begin m_cnt = 0; m_div = !m_div; end
      else m_cnt++;
      void'(m_sq_tk.pop_front()); m_sq_tk.push_back(tk_in);
      void'(m_sq_rk.pop_front()); m_sq_rk.push_back(rk_in);
      m_n = div_n;
      m_src[0] = tx_src; m_mode[0] = tx_omode; m_inv[0] = tx_inv;
      m_src[1] = rx_src; m_mode[1] = rx_omode; m_inv[1] = rx_inv;
    end
  end

  function automatic bit m_base(int d);
    bit pin = (d == 0) ? m_sq_tk[0] : m_sq_rk[0];
    return (m_src[d] == 2) ? pin : m_div;
  endfunction

  function automatic bit m_sel(int d);
    return (m_src[d] == 1) ? m_base(1 - d) : m_base(d);
  endfunction

  function automatic bit m_err(int d);
    return (m_src[d] == 2) && (m_mode[d] == 1);
  endfunction

  function automatic bit m_oe(int d, bit act);
    if (m_err(d)) return 1'b0;
    return (m_mode[d] == 1) || ((m_mode[d] == 2) && act);
  endfunction

  task automatic chk(string what, logic act_v, logic exp_v);
    checks++;
    if (act_v !== exp_v) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk("tx_clk", tx_clk, m_sel(0) ^ m_inv[0]);
      chk("rx_clk", rx_clk, m_sel(1) ^ m_inv[1]);
      chk("tk_pad", tk_out, m_sel(0));
      chk("rk_pad", rk_out, m_sel(1));
      chk("tk_oe",  tk_oe,  m_oe(0, tx_act));
      chk("rk_oe",  rk_oe,  m_oe(1, rx_act));
      chk("tx_err", tx_err, m_err(0));
      chk("rx_err", rx_err, m_err(1));
    end
  end

  always @(posedge clk) begin
    if (pad_rand) begin
      #2;
      tk_in = 1'($urandom);
      rk_in = 1'($urandom);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check_all_low(string t);
    tag = t;
    chk("tx_clk", tx_clk, 0); chk("rx_clk", rx_clk, 0);
    chk("tk_pad", tk_out, 0); chk("rk_pad", rk_out, 0);
    chk("tk_oe", tk_oe, 0);   chk("rk_oe", rk_oe, 0);
    chk("tx_err", tx_err, 0); chk("rx_err", rx_err, 0);
  endtask

  // period between rising edges of tk_pad, sampled at negedges
  task automatic measure_period(int expected);
    int  cnt = 0;
    int  guard = 0;
    bit  prev;
    @(negedge clk); prev = tk_out;
    while (!(tk_out && !prev) && guard < 20000) begin
      prev = tk_out; @(negedge clk); guard++;
    end
    prev = tk_out;
    do begin @(negedge clk); cnt++; if (tk_out && !prev) break; prev = tk_out; end
    while (cnt < 20000);
    checks++;
    if (cnt != expected) begin
      failures++;
      $display("FAIL R1 period actual=%0d expected=%0d", cnt, expected);
    end
    #2;
  endtask

  initial begin
    step(3);
    #1;
    check_all_low("R10 reset");
    rst_n = 1'b1;
    cmp_en = 1'b1;
    step(2);

    // R1 R3 R8: divider source, continuous drive
    tag = "R1 R3 R8";
    div_n = 12'd1; tx_src = 2'b00; tx_omode = 2'b01;
    step(20);
    measure_period(2);
    div_n = 12'd3;
    step(4);
    measure_period(6);

    // R4 R5 R7: rx takes tx-side source, inverted; tx from its pin
    tag = "R4 R5 R7 R6";
    pad_rand = 1'b1;
    rx_src = 2'b01; rx_inv = 1'b1; rx_omode = 2'b01;
    tx_src = 2'b10; tx_omode = 2'b10; tx_act = 1'b1;
    step(30);
    tx_act = 1'b0;
    step(10);

    // R5: both opposite -> both divider
    tag = "R5";
    tx_src = 2'b01; rx_src = 2'b01; tx_inv = 1'b1; rx_inv = 1'b0;
    step(20);

    // R6 R4 R8: rx from pin, transfer-gated driver
    tag = "R6 R4 R8";
    rx_src = 2'b10; rx_omode = 2'b10;
    for (int i = 0; i < 20; i++) begin rx_act = 1'(i % 3 == 0); step(1); end
    rx_act = 1'b0;

    // R9: pin source with continuous drive
    tag = "R9";
    tx_src = 2'b10; tx_omode = 2'b01; rx_omode = 2'b01;
    step(10);

    // R3 R8: reserved encodings
    tag = "R3 R8 reserved";
    tx_src = 2'b11; tx_omode = 2'b11; tx_act = 1'b1;
    rx_src = 2'b11; rx_omode = 2'b11; rx_act = 1'b1;
    step(12);

    // R7 R10: inversion toggled, one-cycle config latency
    tag = "R7 R10";
    for (int i = 0; i < 8; i++) begin tx_inv = ~tx_inv; rx_inv = 1'(i & 1); step(1); end

    // R2: divider off
    tag = "R2";
    tx_src = 2'b00; rx_src = 2'b00; tx_omode = 2'b01;
    div_n = 12'd0;
    step(15);

    // R1: slowest setting
    pad_rand = 1'b0;
    tag = "R1 slow";
    tx_inv = 1'b0;
    div_n = 12'd4095;
    step(2);
    measure_period(8190);

    // R10: mid-run reset
    rst_n = 1'b0;
    cmp_en = 1'b0;
    #1;
    check_all_low("R10 mid reset");
    step(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule